// File: doc/BRIEF.md
# Static Branch Direction Guesser with Hint Override

This block sits beside the fetch stage and guesses, in the same cycle a conditional branch is presented, whether the branch will be taken. With no hint attached, it uses the target's position relative to the branch address. A target at or below the branch address is taken to close a loop and is guessed taken. A target above the branch address is guessed not taken. When the instruction carries a compiler hint, the hinted direction is used and the address comparison is ignored. The block also drives the address fetch should move to next: the target for a taken guess, and the next sequential address otherwise.

Later, the execute stage reports how the branch actually resolved, together with the direction that was guessed for it. On a wrong guess, the block raises a one-cycle pulse and presents the address fetch has to restart from. The fetch unit uses that pulse to drop the instructions it fetched on the wrong path. A saturating counter keeps a tally of wrong guesses. Flushing the pipeline is left to the fetch unit.

Top module: `static_branch_guess`

## Requirements
- R1: With the fetch strobe high and no hint, a target numerically lower than the branch address gives `predTaken` = 1 in the same cycle.
- R2: With the fetch strobe high and no hint, a target numerically higher than the branch address gives `predTaken` = 0.
- R3: With no hint, a target equal to the branch address is treated as backward and gives `predTaken` = 1.
- R4: When `hintPresent` = 1, `predTaken` equals `hintTaken` (1 = taken), whatever the target direction.
- R5: `predNextPc` equals the target when `predTaken` = 1, and the branch address plus one otherwise, wrapping modulo 2^PC_W.
- R6: With the fetch strobe low, `predTaken` = 0 and `predNextPc` is the branch address plus one.
- R7: When a resolution strobe carries a guessed direction that differs from the actual direction, `mispredict` is high for exactly the next cycle, and `fixNextPc` is the resolved target if the branch was actually taken, or the branch address plus one if it was not.
- R8: A resolution whose guessed and actual directions agree, or any cycle with the resolution strobe low, leaves `mispredict` low the next cycle and `missCount` unchanged.
- R9: Each wrong guess increments `missCount` by one in the cycle `mispredict` rises. Once the counter holds its all-ones value (65535 by default), it stays there.
- R10: An active-low reset clears `missCount` and `mispredict`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A conditional branch is presented this cycle |
| fetchPc | input | PC_W | Address of the branch being fetched |
| fetchTarget | input | PC_W | Decoded target address of that branch |
| hintPresent | input | 1 | The branch carries a compiler direction hint |
| hintTaken | input | 1 | Hinted direction, 1 = taken |
| predTaken | output | 1 | Guessed direction, combinational |
| predNextPc | output | PC_W | Address to fetch next, combinational |
| resValid | input | 1 | A branch resolved this cycle |
| resPredTaken | input | 1 | Direction that was guessed for the resolving branch |
| resActualTaken | input | 1 | Actual direction of the resolving branch |
| resPc | input | PC_W | Address of the resolving branch |
| resTarget | input | PC_W | Target of the resolving branch |
| mispredict | output | 1 | One-cycle pulse after a wrong guess |
| fixNextPc | output | PC_W | Correct restart address, valid with `mispredict` |
| missCount | output | CNT_W | Saturating count of wrong guesses |

## Verification
The guessed direction and the fetch address come from logic with no register on the path, so they are due in the same cycle the fetch inputs are applied. The restart pulse, the restart address and the counter value are each one register behind the resolution inputs, so they are due one cycle after a resolution is applied. The driver stamps each expected item with the cycle count at which it is due. The monitor samples a few nanoseconds after every rising edge, while the inputs are still held, and compares only the items whose due cycle has arrived. The saturation case runs enough back-to-back wrong guesses to drive the counter past its all-ones value.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic takeSel;    // choose the target as next fetch address
    logic missLoad;   // capture a restart address and raise the pulse
    logic missTaken;  // actual direction of the mispredicted branch
    logic cntInc;     // bump the wrong-guess tally
  } sbpStrobes_t;
endpackage

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
(
  input  logic        fetchValid,
  input  logic        hintPresent,
  input  logic        hintTaken,
  input  logic        isBackward,
  input  logic        resValid,
  input  logic        resPredTaken,
  input  logic        resActualTaken,
  output logic        predTaken,
  output sbpStrobes_t strb
);
  logic guessDir;
  logic wrongGuess;

  // A present hint overrides the address-direction rule
  always_comb begin
    if (hintPresent) guessDir = hintTaken;
    else             guessDir = isBackward;
  end

  assign predTaken  = fetchValid & guessDir;
  assign wrongGuess = resValid & (resPredTaken ^ resActualTaken);

  always_comb begin
    strb.takeSel   = predTaken;
    strb.missLoad  = wrongGuess;
    strb.missTaken = resActualTaken;
    strb.cntInc    = wrongGuess;
  end
endmodule

// File: rtl/sbp_dpath.sv
module sbp_dpath
  import sbp_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  fetchTarget,
  input  logic [PC_W-1:0]  resPc,
  input  logic [PC_W-1:0]  resTarget,
  input  sbpStrobes_t      strb,
  output logic             isBackward,
  output logic [PC_W-1:0]  predNextPc,
  output logic             mispredict,
  output logic [PC_W-1:0]  fixNextPc,
  output logic [CNT_W-1:0] missCount
);
  localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PC_W-1:0] fetchSeq;
  logic [PC_W-1:0] resSeq;
  logic [PC_W-1:0] restartPc;
  logic            cntFull;

  // Equal target counts as backward
  assign isBackward = (fetchTarget <= fetchPc);
  assign fetchSeq   = fetchPc + PC_ONE;
  assign resSeq     = resPc + PC_ONE;
  assign predNextPc = strb.takeSel ? fetchTarget : fetchSeq;
  assign restartPc  = strb.missTaken ? resTarget : resSeq;
  assign cntFull    = (missCount == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mispredict <= 1'b0;
      fixNextPc  <= '0;
    end else begin
      mispredict <= strb.missLoad;
      if (strb.missLoad) fixNextPc <= restartPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                        missCount <= '0;
    else if (strb.cntInc && !cntFull) missCount <= missCount + CNT_ONE;
  end
endmodule

// File: rtl/static_branch_guess.sv
module static_branch_guess
  import sbp_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  fetchTarget,
  input  logic             hintPresent,
  input  logic             hintTaken,
  output logic             predTaken,
  output logic [PC_W-1:0]  predNextPc,
  input  logic             resValid,
  input  logic             resPredTaken,
  input  logic             resActualTaken,
  input  logic [PC_W-1:0]  resPc,
  input  logic [PC_W-1:0]  resTarget,
  output logic             mispredict,
  output logic [PC_W-1:0]  fixNextPc,
  output logic [CNT_W-1:0] missCount
);
  sbpStrobes_t strb;
  logic        isBackward;

  sbp_ctrl uCtrl (
    .fetchValid     (fetchValid),
    .hintPresent    (hintPresent),
    .hintTaken      (hintTaken),
    .isBackward     (isBackward),
    .resValid       (resValid),
    .resPredTaken   (resPredTaken),
    .resActualTaken (resActualTaken),
    .predTaken      (predTaken),
    .strb           (strb)
  );

  sbp_dpath #(.PC_W(PC_W), .CNT_W(CNT_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .fetchPc     (fetchPc),
    .fetchTarget (fetchTarget),
    .resPc       (resPc),
    .resTarget   (resTarget),
    .strb        (strb),
    .isBackward  (isBackward),
    .predNextPc  (predNextPc),
    .mispredict  (mispredict),
    .fixNextPc   (fixNextPc),
    .missCount   (missCount)
  );
endmodule

// File: rtl/sbp_check.sv
module sbp_check #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             fetchValid,
  input logic [PC_W-1:0]  fetchPc,
  input logic [PC_W-1:0]  fetchTarget,
  input logic             hintPresent,
  input logic             hintTaken,
  input logic             predTaken,
  input logic [PC_W-1:0]  predNextPc,
  input logic             resValid,
  input logic             resPredTaken,
  input logic             resActualTaken,
  input logic [PC_W-1:0]  resPc,
  input logic [PC_W-1:0]  resTarget,
  input logic             mispredict,
  input logic [PC_W-1:0]  fixNextPc,
  input logic [CNT_W-1:0] missCount
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  assert_backward_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !hintPresent && fetchTarget < fetchPc) |-> predTaken);

  assert_forward_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !hintPresent && fetchTarget > fetchPc) |-> !predTaken);

  assert_hint_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && hintPresent) |-> (predTaken == hintTaken));

  assert_next_pc_R5: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> (predNextPc == fetchTarget));

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |-> !predTaken);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resPredTaken != resActualTaken)) |=> mispredict);

  assert_fix_pc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resActualTaken && !resPredTaken) |=> (fixNextPc == $past(resTarget)));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && (resPredTaken != resActualTaken)) |=> !mispredict);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(resValid && (resPredTaken != resActualTaken)) |=> $stable(missCount));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (missCount == FULL) |=> (missCount == FULL));

  assert_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mispredict && $past(rstN) && $past(missCount) != FULL) |->
      (missCount == $past(missCount) + CNT_W'(1)));

  // Only checks that the inputs are used, keeps every port read
  logic unusedSink;
  assign unusedSink = ^{resPc, fixNextPc};
endmodule

bind static_branch_guess sbp_check #(.PC_W(PC_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
  .fetchTarget(fetchTarget), .hintPresent(hintPresent), .hintTaken(hintTaken),
  .predTaken(predTaken), .predNextPc(predNextPc), .resValid(resValid),
  .resPredTaken(resPredTaken), .resActualTaken(resActualTaken), .resPc(resPc),
  .resTarget(resTarget), .mispredict(mispredict), .fixNextPc(fixNextPc),
  .missCount(missCount)
);

// File: tb/sim_static_branch_guess.sv
module sim_static_branch_guess;
  localparam int PC_W  = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             fetchValid = 1'b0;
  logic [PC_W-1:0]  fetchPc = '0;
  logic [PC_W-1:0]  fetchTarget = '0;
  logic             hintPresent = 1'b0;
  logic             hintTaken = 1'b0;
  logic             predTaken;
  logic [PC_W-1:0]  predNextPc;
  logic             resValid = 1'b0;
  logic             resPredTaken = 1'b0;
  logic             resActualTaken = 1'b0;
  logic [PC_W-1:0]  resPc = '0;
  logic [PC_W-1:0]  resTarget = '0;
  logic             mispredict;
  logic [PC_W-1:0]  fixNextPc;
  logic [CNT_W-1:0] missCount;

  static_branch_guess #(.PC_W(PC_W), .CNT_W(CNT_W)) u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    int               due;
    int               req;
    bit               isRes;
    logic             expTaken;
    logic [PC_W-1:0]  expNext;
    logic             expMiss;
    logic [PC_W-1:0]  expFix;
    logic [CNT_W-1:0] expCnt;
  } item_t;

  item_t            sbq[$];
  int               cyc = 0;
  int               checks = 0;
  int               errors = 0;
  logic [CNT_W-1:0] modelCnt = '0;
  bit               done = 0;

  task automatic fail(input int req, input string what, input longint act, input longint exp);
    errors++;
    $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  // Driver: applies one cycle of stimulus and queues what it predicts
  task automatic step(input bit fv, input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tg,
                      input bit hp, input bit ht, input bit rv, input bit rpt, input bit rat,
                      input logic [PC_W-1:0] rpc, input logic [PC_W-1:0] rtg,
                      input int fReq, input int rReq, input bit chk);
    item_t it;
    bit guess, miss;
    @(negedge clk);
    fetchValid = fv; fetchPc = pc; fetchTarget = tg; hintPresent = hp; hintTaken = ht;
    resValid = rv; resPredTaken = rpt; resActualTaken = rat; resPc = rpc; resTarget = rtg;
    guess = hp ? ht : (tg <= pc);
    miss  = rv && (rpt != rat);
    if (miss && modelCnt != {CNT_W{1'b1}}) modelCnt++;
    if (chk) begin
      it = '{due: cyc + 1, req: fReq, isRes: 0, expTaken: fv & guess,
             expNext: (fv & guess) ? tg : pc + 1'b1, expMiss: 0, expFix: '0, expCnt: '0};
      sbq.push_back(it);
      it = '{due: cyc + 1, req: rReq, isRes: 1, expTaken: 0, expNext: '0,
             expMiss: miss, expFix: rat ? rtg : rpc + 1'b1, expCnt: modelCnt};
      sbq.push_back(it);
    end
  endtask

  task automatic fetchOnly(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tg,
                           input bit hp, input bit ht, input int req);
    step(1, pc, tg, hp, ht, 0, 0, 0, '0, '0, req, 8, 1);
  endtask

  task automatic resOnly(input bit rpt, input bit rat, input logic [PC_W-1:0] rpc,
                         input logic [PC_W-1:0] rtg, input int req);
    step(0, 16'h0100, 16'h0200, 0, 0, 1, rpt, rat, rpc, rtg, 6, req, 1);
  endtask

  // Monitor: samples 3 ns after each rising edge, inputs still held
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      cyc++;
      #3;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        it = sbq.pop_front();
        checks++;
        if (!it.isRes) begin
          if (predTaken !== it.expTaken) fail(it.req, "predTaken", predTaken, it.expTaken);
          else if (predNextPc !== it.expNext) fail(it.req, "predNextPc", predNextPc, it.expNext);
        end else begin
          if (mispredict !== it.expMiss) fail(it.req, "mispredict", mispredict, it.expMiss);
          else if (it.expMiss && fixNextPc !== it.expFix) fail(it.req, "fixNextPc", fixNextPc, it.expFix);
          else if (missCount !== it.expCnt) fail(9, "missCount", missCount, it.expCnt);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++; if (missCount !== '0) fail(10, "reset missCount", missCount, 0);
    checks++; if (mispredict !== 1'b0) fail(10, "reset mispredict", mispredict, 0);

    // R1 backward, R2 forward, R3 equal
    fetchOnly(16'h0400, 16'h03F0, 0, 0, 1);
    fetchOnly(16'h0400, 16'h0410, 0, 0, 2);
    fetchOnly(16'h1234, 16'h1234, 0, 0, 3);
    fetchOnly(16'h8000, 16'h0001, 0, 0, 1);
    // R4 hints override both directions
    fetchOnly(16'h0400, 16'h03F0, 1, 0, 4);
    fetchOnly(16'h0400, 16'h0410, 1, 1, 4);
    fetchOnly(16'h0400, 16'h0410, 1, 0, 4);
    // R5 wrap of sequential address
    fetchOnly(16'hFFFF, 16'h0000, 1, 0, 5);
    fetchOnly(16'hFFFF, 16'h0010, 0, 0, 5);
    // R6 no fetch strobe
    step(0, 16'h0050, 16'h0010, 1, 1, 0, 0, 0, '0, '0, 6, 8, 1);
    // R7 wrong guesses both ways, R8 agreeing resolution
    resOnly(0, 1, 16'h0200, 16'h0180, 7);
    resOnly(1, 0, 16'h0300, 16'h0280, 7);
    resOnly(1, 1, 16'h0300, 16'h0280, 8);
    resOnly(0, 0, 16'h0300, 16'h0280, 8);
    resOnly(1, 0, 16'hFFFF, 16'h0004, 7);
    step(0, '0, '0, 0, 0, 0, 1, 0, 16'h0700, '0, 6, 8, 1);
    // R10 reset mid-run clears the tally
    @(negedge clk); resValid = 0; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; modelCnt = '0;
    #1;
    checks++; if (missCount !== '0) fail(10, "mid reset missCount", missCount, 0);
    checks++; if (mispredict !== 1'b0) fail(10, "mid reset mispredict", mispredict, 0);
    // R9 saturation: run past the all-ones value
    for (int i = 0; i < (1 << CNT_W) + 3; i++)
      step(0, '0, '0, 0, 0, 1, 0, 1, 16'h0010, 16'h0020, 6, 9, (i >= (1 << CNT_W) - 3));
    resOnly(1, 1, 16'h0010, 16'h0020, 9);
    step(0, '0, '0, 0, 0, 0, 0, 0, '0, '0, 6, 8, 0);
    repeat (3) @(negedge clk);
    checks++; if (sbq.size() != 0) fail(9, "scoreboard drained", sbq.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule